// File: doc/BRIEF.md
# Zero-Register File with Block Transfers

This block is the integer register file of a wide-register execution core: 256 registers of 64 bits, each picked by an 8-bit index, where index 0 always reads zero and swallows every write. One asynchronous read port serves operand fetch. A single command port accepts one of four operations per cycle: a plain register write, a swap of two registers, a wide write of up to 32 bytes that spills little-endian into the following registers, and a block copy of a run of consecutive registers.

The block copy runs in the background at one register per cycle, and `busy` stays high while it runs. Overlapping source and destination runs give the result a copy through a temporary buffer would give. A copy or wide write whose range would pass the last register is refused as a whole and answered with a one-cycle `exc` pulse.

Top module: `zero_reg_file`

## Requirements
- R1: After reset every register reads zero, `busy` is 0 and `exc` is 0.
- R2: `rd_data` shows the register selected by `rd_idx` in the same cycle; index 0 always reads zero, whatever command has targeted it.
- R3: With `wr_en`, bits [63:0] of `wr_data` are stored into register `idx_a` and can be read from the next cycle on.
- R4: With `swap_en`, registers `idx_a` and `idx_b` exchange contents; if both indices are 0 nothing changes; if exactly one is 0 the other register becomes zero.
- R5: With `copy_en`, `reg_cnt` registers starting at `idx_b` are copied to the run starting at `idx_a`; when the runs overlap the destination receives the contents the source held before the copy; a source register 0 delivers zero and a write to register 0 is dropped.
- R6: An accepted copy of N>0 registers raises `busy` the cycle after the command and keeps it high for exactly N cycles; a copy with `reg_cnt` of 0 changes nothing and never raises `busy`.
- R7: A copy with `idx_b + reg_cnt > 256` or `idx_a + reg_cnt > 256` (and `reg_cnt` non-zero) modifies no register, does not raise `busy`, and raises `exc` for exactly the one cycle after the command.
- R8: With `wide_en`, `byte_cnt` bytes of `wr_data` are written: byte k (bits 8k+7..8k) goes to byte k mod 8 of register `idx_a + k/8`, byte 0 being the least significant; bytes of the last register beyond the count keep their value; the part aimed at register 0 is dropped.
- R9: A wide write with `byte_cnt > 32`, or with `idx_a + ceil(byte_cnt/8) > 256`, writes nothing and raises `exc` for the one cycle after the command; a `byte_cnt` of 0 does nothing.
- R10: When several strobes are high in one cycle only one command runs, in the order `copy_en`, then `swap_en`, then `wide_en`, then `wr_en`; the others are dropped.
- R11: While `busy` is high every command strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_idx | input | 8 | Read index |
| rd_data | output | 64 | Contents of register `rd_idx` |
| wr_en | input | 1 | Plain write strobe |
| swap_en | input | 1 | Swap strobe |
| wide_en | input | 1 | Wide write strobe |
| copy_en | input | 1 | Block copy strobe |
| idx_a | input | 8 | Write target, first swap operand, copy destination start |
| idx_b | input | 8 | Second swap operand, copy source start |
| wr_data | input | 256 | Write data; plain write uses bits [63:0] |
| byte_cnt | input | 6 | Byte count of a wide write |
| reg_cnt | input | 9 | Register count of a block copy |
| busy | output | 1 | Block copy in progress |
| exc | output | 1 | One-cycle pulse after a refused out-of-range command |

## Verification
The bench targets overlapping copies in both directions, where a design that walks in a fixed order would smear the first source value across the run, and copies involving register 0, where a design could leak a stored value out of it or write into it. It probes the exact range limits, one past and exactly at register 255, for both copy and wide write, since an off-by-one either refuses a legal command or wraps writes into the low registers. A partial last register of a wide write checks that untouched bytes keep their old value instead of being cleared, and simultaneous strobes or strobes during a running copy catch a decode that lets a second command slip through.

// File: rtl/zrf_pkg.sv
// Shared types of the zero-register file.
// Assumes nothing beyond being compiled before the modules that import it.
package zrf_pkg;

    // Direction in which the block copy walks through the register run.
    typedef enum logic {
        WALK_UP   = 1'b0,
        WALK_DOWN = 1'b1
    } walk_dir_e;

endpackage

// File: rtl/zrf_decode.sv
// Command decode and range check for the zero-register file.
// Picks one command per cycle by fixed priority, refuses copy and wide
// write commands that would pass the last register, and computes the
// start point and walk direction of an accepted block copy.
// Assumes NREGS is a power of two and XLEN a multiple of 8 whose byte
// count is a power of two.
module zrf_decode
    import zrf_pkg::*;
#(
    parameter int NREGS          = 256,
    parameter int XLEN           = 64,
    parameter int MAX_WIDE_BYTES = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             busy,
    input  logic                             wr_en,
    input  logic                             swap_en,
    input  logic                             wide_en,
    input  logic                             copy_en,
    input  logic [$clog2(NREGS)-1:0]         idx_a,
    input  logic [$clog2(NREGS)-1:0]         idx_b,
    input  logic [$clog2(MAX_WIDE_BYTES+1)-1:0] byte_cnt,
    input  logic [$clog2(NREGS+1)-1:0]       reg_cnt,
    output logic                             wr_go,
    output logic                             sw_go,
    output logic                             wd_go,
    output logic                             cp_start,
    output walk_dir_e                        cp_dir,
    output logic [$clog2(NREGS)-1:0]         cp_src0,
    output logic [$clog2(NREGS)-1:0]         cp_dst0,
    output logic                             exc
);
    localparam int IDXW   = $clog2(NREGS);
    localparam int BCW    = $clog2(MAX_WIDE_BYTES + 1);
    localparam int CCW    = $clog2(NREGS + 1);
    localparam int BPR    = XLEN / 8;
    localparam int BPR_SH = $clog2(BPR);
    localparam int SUMW   = ((CCW > BCW) ? CCW : BCW) + 2;

    logic            idle;
    logic            pick_cp, pick_sw, pick_wd, pick_wr;
    logic [SUMW-1:0] a_ext, b_ext, rc_ext, bc_ext, span_ext;
    logic [SUMW-1:0] src_hi, dst_hi;
    logic            cp_bad, wd_bad, cp_live, wd_live;

    // Priority selection: copy, swap, wide write, plain write; none while busy.
    always_comb begin
        idle    = !busy;
        pick_cp = idle && copy_en;
        pick_sw = idle && !copy_en && swap_en;
        pick_wd = idle && !copy_en && !swap_en && wide_en;
        pick_wr = idle && !copy_en && !swap_en && !wide_en && wr_en;
    end

    // Range arithmetic in a width that cannot overflow.
    always_comb begin
        a_ext    = SUMW'(idx_a);
        b_ext    = SUMW'(idx_b);
        rc_ext   = SUMW'(reg_cnt);
        bc_ext   = SUMW'(byte_cnt);
        span_ext = (bc_ext + SUMW'(BPR - 1)) >> BPR_SH;
        cp_bad   = (b_ext + rc_ext > SUMW'(NREGS)) || (a_ext + rc_ext > SUMW'(NREGS));
        wd_bad   = (bc_ext > SUMW'(MAX_WIDE_BYTES)) || (a_ext + span_ext > SUMW'(NREGS));
        cp_live  = pick_cp && (reg_cnt != '0);
        wd_live  = pick_wd && (byte_cnt != '0);
        src_hi   = b_ext + rc_ext - SUMW'(1);
        dst_hi   = a_ext + rc_ext - SUMW'(1);
    end

    // Command outputs and copy start point; a downward walk starts at the top.
    always_comb begin
        wr_go    = pick_wr;
        sw_go    = pick_sw;
        wd_go    = wd_live && !wd_bad;
        cp_start = cp_live && !cp_bad;
        cp_dir   = (idx_a > idx_b) ? WALK_DOWN : WALK_UP;
        cp_src0  = (cp_dir == WALK_DOWN) ? src_hi[IDXW-1:0] : idx_b;
        cp_dst0  = (cp_dir == WALK_DOWN) ? dst_hi[IDXW-1:0] : idx_a;
    end

    // Exception pulse for the cycle after a refused command.
    always_ff @(posedge clk) begin
        if (!rst_n) exc <= 1'b0;
        else        exc <= (cp_live && cp_bad) || (wd_live && wd_bad);
    end

    // R7
    exc_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc |-> !busy);

    // R11
    idle_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(wr_go || sw_go || wd_go || cp_start));

endmodule

// File: rtl/zrf_copy_seq.sv
// Block copy sequencer for the zero-register file.
// Walks source and destination pointers one register per cycle in the
// direction chosen at start, so overlapping runs copy correctly.
// Assumes start is only raised while the sequencer is idle and that the
// length is non-zero and already range checked.
module zrf_copy_seq
    import zrf_pkg::*;
#(
    parameter int NREGS = 256
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  walk_dir_e                  dir,
    input  logic [$clog2(NREGS)-1:0]   src0,
    input  logic [$clog2(NREGS)-1:0]   dst0,
    input  logic [$clog2(NREGS+1)-1:0] len,
    output logic                       busy,
    output logic                       step_en,
    output logic [$clog2(NREGS)-1:0]   step_src,
    output logic [$clog2(NREGS)-1:0]   step_dst
);
    localparam int IDXW = $clog2(NREGS);
    localparam int CCW  = $clog2(NREGS + 1);

    logic [IDXW-1:0] src_q, dst_q;
    logic [CCW-1:0]  left_q;
    walk_dir_e       dir_q;

    // Load the run on start, then advance one register per busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            src_q  <= '0;
            dst_q  <= '0;
            left_q <= '0;
            dir_q  <= WALK_UP;
        end else if (start) begin
            busy   <= 1'b1;
            src_q  <= src0;
            dst_q  <= dst0;
            left_q <= len;
            dir_q  <= dir;
        end else if (busy) begin
            src_q  <= (dir_q == WALK_DOWN) ? src_q - 1'b1 : src_q + 1'b1;
            dst_q  <= (dir_q == WALK_DOWN) ? dst_q - 1'b1 : dst_q + 1'b1;
            left_q <= left_q - 1'b1;
            if (left_q == CCW'(1)) busy <= 1'b0;
        end
    end

    // Current step presented to the storage array.
    always_comb begin
        step_en  = busy;
        step_src = src_q;
        step_dst = dst_q;
    end

    // R6
    copy_begin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    // R6
    copy_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> left_q != '0);

    // R6
    copy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && left_q == CCW'(1)) |=> !busy);

endmodule

// File: rtl/zrf_cell_array.sv
// Storage array of the zero-register file.
// Entry 0 is a constant zero; every other entry is a flop word with its own
// next-value logic for plain write, swap, copy step and byte-masked wide write.
// Assumes at most one of the four enables is high in any cycle and that the
// wide write range has been checked by the caller.
module zrf_cell_array #(
    parameter int NREGS          = 256,
    parameter int XLEN           = 64,
    parameter int MAX_WIDE_BYTES = 32
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [$clog2(NREGS)-1:0]            rd_idx,
    output logic [XLEN-1:0]                     rd_data,
    input  logic                                wr_en,
    input  logic [$clog2(NREGS)-1:0]            wr_idx,
    input  logic [XLEN-1:0]                     wr_val,
    input  logic                                sw_en,
    input  logic [$clog2(NREGS)-1:0]            sw_a,
    input  logic [$clog2(NREGS)-1:0]            sw_b,
    input  logic                                cp_en,
    input  logic [$clog2(NREGS)-1:0]            cp_src,
    input  logic [$clog2(NREGS)-1:0]            cp_dst,
    input  logic                                wd_en,
    input  logic [$clog2(NREGS)-1:0]            wd_base,
    input  logic [$clog2(MAX_WIDE_BYTES+1)-1:0] wd_bytes,
    input  logic [MAX_WIDE_BYTES*8-1:0]         wd_data
);
    localparam int IDXW     = $clog2(NREGS);
    localparam int BCW      = $clog2(MAX_WIDE_BYTES + 1);
    localparam int BPR      = XLEN / 8;
    localparam int MAX_SPAN = (MAX_WIDE_BYTES + BPR - 1) / BPR;

    logic [XLEN-1:0] mem [NREGS];
    logic [XLEN-1:0] val_a, val_b, val_src;

    // Read ports: operand fetch, swap operands, copy source.
    always_comb begin
        rd_data = mem[rd_idx];
        val_a   = mem[sw_a];
        val_b   = mem[sw_b];
        val_src = mem[cp_src];
    end

    for (genvar gi = 0; gi < NREGS; gi++) begin : g_cell
        if (gi == 0) begin : g_zero
            assign mem[gi] = '0;
        end else begin : g_live
            localparam logic [IDXW-1:0] MY_IDX = IDXW'(gi);
            logic [XLEN-1:0] q, nxt;
            logic [IDXW-1:0] off;

            assign off = MY_IDX - wd_base;

            // Next value of this register from whichever command targets it.
            always_comb begin
                nxt = q;
                if (wr_en && wr_idx == MY_IDX) nxt = wr_val;
                if (sw_en) begin
                    if (sw_a == MY_IDX)      nxt = val_b;
                    else if (sw_b == MY_IDX) nxt = val_a;
                end
                if (cp_en && cp_dst == MY_IDX) nxt = val_src;
                if (wd_en) begin
                    for (int k = 0; k < MAX_SPAN; k++) begin
                        if (off == IDXW'(k)) begin
                            for (int j = 0; j < BPR; j++) begin
                                if (BCW'(k * BPR + j) < wd_bytes)
                                    nxt[8*j +: 8] = wd_data[8*(k*BPR + j) +: 8];
                            end
                        end
                    end
                end
            end

            // Register word with synchronous clear.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= '0;
                else        q <= nxt;
            end

            assign mem[gi] = q;
        end
    end

    // R10
    one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, sw_en, cp_en, wd_en}));

    // R3
    plain_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx != '0) |=> mem[$past(wr_idx)] == $past(wr_val));

    // R4
    swap_xchg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en && sw_a != '0 && sw_b != '0)
        |=> (mem[$past(sw_a)] == $past(val_b)) && (mem[$past(sw_b)] == $past(val_a)));

    // R4
    swap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en && sw_a == '0 && sw_b != '0) |=> mem[$past(sw_b)] == '0);

    // R5
    copy_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_en && cp_dst != '0) |=> mem[$past(cp_dst)] == $past(val_src));

    // R2
    zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx == '0) |-> rd_data == '0);

endmodule

// File: rtl/zero_reg_file.sv
// Zero-register file with swap, block copy and spilling wide write.
// Ties the command decode, the copy sequencer and the storage array
// together; one command is taken per cycle while no copy is running.
// Assumes NREGS is a power of two and XLEN a multiple of 8.
module zero_reg_file #(
    parameter int NREGS          = 256,
    parameter int XLEN           = 64,
    parameter int MAX_WIDE_BYTES = 32
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [$clog2(NREGS)-1:0]            rd_idx,
    output logic [XLEN-1:0]                     rd_data,
    input  logic                                wr_en,
    input  logic                                swap_en,
    input  logic                                wide_en,
    input  logic                                copy_en,
    input  logic [$clog2(NREGS)-1:0]            idx_a,
    input  logic [$clog2(NREGS)-1:0]            idx_b,
    input  logic [MAX_WIDE_BYTES*8-1:0]         wr_data,
    input  logic [$clog2(MAX_WIDE_BYTES+1)-1:0] byte_cnt,
    input  logic [$clog2(NREGS+1)-1:0]          reg_cnt,
    output logic                                busy,
    output logic                                exc
);
    import zrf_pkg::*;

    localparam int IDXW = $clog2(NREGS);

    logic            wr_go, sw_go, wd_go, cp_start;
    walk_dir_e       cp_dir;
    logic [IDXW-1:0] cp_src0, cp_dst0;
    logic            step_en;
    logic [IDXW-1:0] step_src, step_dst;

    zrf_decode #(
        .NREGS(NREGS), .XLEN(XLEN), .MAX_WIDE_BYTES(MAX_WIDE_BYTES)
    ) u_decode (
        .clk(clk), .rst_n(rst_n), .busy(busy),
        .wr_en(wr_en), .swap_en(swap_en), .wide_en(wide_en), .copy_en(copy_en),
        .idx_a(idx_a), .idx_b(idx_b), .byte_cnt(byte_cnt), .reg_cnt(reg_cnt),
        .wr_go(wr_go), .sw_go(sw_go), .wd_go(wd_go), .cp_start(cp_start),
        .cp_dir(cp_dir), .cp_src0(cp_src0), .cp_dst0(cp_dst0), .exc(exc)
    );

    zrf_copy_seq #(
        .NREGS(NREGS)
    ) u_copy (
        .clk(clk), .rst_n(rst_n), .start(cp_start), .dir(cp_dir),
        .src0(cp_src0), .dst0(cp_dst0), .len(reg_cnt),
        .busy(busy), .step_en(step_en), .step_src(step_src), .step_dst(step_dst)
    );

    zrf_cell_array #(
        .NREGS(NREGS), .XLEN(XLEN), .MAX_WIDE_BYTES(MAX_WIDE_BYTES)
    ) u_cells (
        .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_data(rd_data),
        .wr_en(wr_go), .wr_idx(idx_a), .wr_val(wr_data[XLEN-1:0]),
        .sw_en(sw_go), .sw_a(idx_a), .sw_b(idx_b),
        .cp_en(step_en), .cp_src(step_src), .cp_dst(step_dst),
        .wd_en(wd_go), .wd_base(idx_a), .wd_bytes(byte_cnt), .wd_data(wr_data)
    );

endmodule

// File: tb/zero_reg_file_tb.sv
`timescale 1ns/1ps
module zero_reg_file_tb;
    logic         clk = 1'b0;
    logic         rst_n;
    logic [7:0]   rd_idx;
    logic [63:0]  rd_data;
    logic         wr_en, swap_en, wide_en, copy_en;
    logic [7:0]   idx_a, idx_b;
    logic [255:0] wr_data;
    logic [5:0]   byte_cnt;
    logic [8:0]   reg_cnt;
    logic         busy, exc;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    zero_reg_file u_dut (
        .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_data(rd_data),
        .wr_en(wr_en), .swap_en(swap_en), .wide_en(wide_en), .copy_en(copy_en),
        .idx_a(idx_a), .idx_b(idx_b), .wr_data(wr_data),
        .byte_cnt(byte_cnt), .reg_cnt(reg_cnt), .busy(busy), .exc(exc)
    );

    // op: 0 plain write, 1 swap, 2 no command
    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  a;
        logic [7:0]  b;
        logic [63:0] data;
        logic [7:0]  chk;
        logic [63:0] exp;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t TBL [NVEC] = '{
        '{2'd0, 8'd5,   8'd0, 64'h1111,               8'd5,   64'h1111},
        '{2'd0, 8'd6,   8'd0, 64'h2222,               8'd6,   64'h2222},
        '{2'd0, 8'd0,   8'd0, 64'hDEAD,               8'd0,   64'h0},
        '{2'd1, 8'd5,   8'd6, 64'h0,                  8'd5,   64'h2222},
        '{2'd2, 8'd0,   8'd0, 64'h0,                  8'd6,   64'h1111},
        '{2'd1, 8'd0,   8'd6, 64'h0,                  8'd6,   64'h0},
        '{2'd1, 8'd0,   8'd0, 64'h0,                  8'd5,   64'h2222},
        '{2'd1, 8'd5,   8'd5, 64'h0,                  8'd5,   64'h2222},
        '{2'd0, 8'd255, 8'd0, 64'hFFFF_FFFF_FFFF_FFFF, 8'd255, 64'hFFFF_FFFF_FFFF_FFFF},
        '{2'd1, 8'd255, 8'd0, 64'h0,                  8'd255, 64'h0}
    };

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_reg(input string tag, input logic [7:0] idx, input logic [63:0] exp);
        rd_idx = idx;
        #0.5;
        chk(tag, rd_data, exp);
    endtask

    task automatic idle_inputs();
        wr_en = 0; swap_en = 0; wide_en = 0; copy_en = 0;
    endtask

    // Drive one command at a falling edge, return at the next falling edge.
    task automatic issue(input logic c_cp, input logic c_sw, input logic c_wd, input logic c_wr,
                         input logic [7:0] a, input logic [7:0] b,
                         input logic [5:0] bc, input logic [8:0] rc,
                         input logic [255:0] d);
        copy_en = c_cp; swap_en = c_sw; wide_en = c_wd; wr_en = c_wr;
        idx_a = a; idx_b = b; byte_cnt = bc; reg_cnt = rc; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic wr(input logic [7:0] idx, input logic [63:0] v);
        issue(0, 0, 0, 1, idx, 8'd0, 6'd0, 9'd0, {192'b0, v});
    endtask

    // Issue a copy and return the number of cycles busy stayed high.
    task automatic copy_run(input logic [7:0] dst, input logic [7:0] src,
                            input logic [8:0] n, output int cyc);
        issue(1, 0, 0, 0, dst, src, 6'd0, n, 256'b0);
        cyc = 0;
        while (busy && cyc < 600) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    logic [255:0] wd;
    logic [63:0]  v [4];
    localparam logic [63:0] K1 = 64'h100F0E0D0C0B0A09;

    initial begin
        int cyc;
        idle_inputs();
        idx_a = 0; idx_b = 0; byte_cnt = 0; reg_cnt = 0; wr_data = 0; rd_idx = 0;
        for (int k = 0; k < 32; k++) wd[8*k +: 8] = 8'(k + 1);
        for (int i = 0; i < 4; i++) v[i] = 64'h1000 + 64'(i);

        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        chk("R1 busy after reset", {63'b0, busy}, 64'd0);
        chk("R1 exc after reset", {63'b0, exc}, 64'd0);
        chk_reg("R1 r7 after reset", 8'd7, 64'd0);
        chk_reg("R1 r255 after reset", 8'd255, 64'd0);

        // R2 R3 R4: table of writes and swaps
        for (int i = 0; i < NVEC; i++) begin
            if (TBL[i].op == 2'd0)
                issue(0, 0, 0, 1, TBL[i].a, TBL[i].b, 6'd0, 9'd0, {192'b0, TBL[i].data});
            else if (TBL[i].op == 2'd1)
                issue(0, 1, 0, 0, TBL[i].a, TBL[i].b, 6'd0, 9'd0, 256'b0);
            else
                @(negedge clk);
            chk_reg($sformatf("R2/R3/R4 vector %0d", i), TBL[i].chk, TBL[i].exp);
        end

        // R8: wide write with partial last register
        wr(8'd101, 64'hAAAA_AAAA_AAAA_AAAA);
        issue(0, 0, 1, 0, 8'd100, 8'd0, 6'd13, 9'd0, wd);
        chk_reg("R8 wide r100", 8'd100, 64'h0807060504030201);
        chk_reg("R8 wide r101 partial", 8'd101, 64'hAAAAAA0D0C0B0A09);
        chk_reg("R8 wide r102 untouched", 8'd102, 64'd0);
        // R8: wide write starting at register 0
        issue(0, 0, 1, 0, 8'd0, 8'd0, 6'd32, 9'd0, wd);
        chk_reg("R8 wide r0 stays zero", 8'd0, 64'd0);
        chk_reg("R8 wide r1", 8'd1, K1);
        chk_reg("R8 wide r3", 8'd3, 64'h201F1E1D1C1B1A19);
        // R9: range limits of wide write
        wr(8'd254, 64'h55);
        issue(0, 0, 1, 0, 8'd254, 8'd0, 6'd24, 9'd0, wd);
        chk("R9 wide past end exc", {63'b0, exc}, 64'd1);
        chk_reg("R9 wide past end r254 kept", 8'd254, 64'h55);
        @(negedge clk);
        chk("R9 exc single cycle", {63'b0, exc}, 64'd0);
        issue(0, 0, 1, 0, 8'd110, 8'd0, 6'd33, 9'd0, wd);
        chk("R9 wide count 33 exc", {63'b0, exc}, 64'd1);
        chk_reg("R9 wide count 33 r110", 8'd110, 64'd0);
        issue(0, 0, 1, 0, 8'd253, 8'd0, 6'd24, 9'd0, wd);
        chk("R9 wide to r255 no exc", {63'b0, exc}, 64'd0);
        chk_reg("R9 wide to r255 r255", 8'd255, 64'h1817161514131211);
        issue(0, 0, 1, 0, 8'd120, 8'd0, 6'd0, 9'd0, wd);
        chk("R9 wide zero count no exc", {63'b0, exc}, 64'd0);
        chk_reg("R9 wide zero count r120", 8'd120, 64'd0);

        // R5 R6: plain copy
        for (int i = 0; i < 4; i++) wr(8'(10 + i), v[i]);
        copy_run(8'd20, 8'd10, 9'd4, cyc);
        chk("R6 busy cycles copy of 4", 64'(cyc), 64'd4);
        for (int i = 0; i < 4; i++) chk_reg("R5 copy forward", 8'(20 + i), v[i]);
        // R5: overlap, destination above source
        copy_run(8'd11, 8'd10, 9'd4, cyc);
        for (int i = 0; i < 4; i++) chk_reg("R5 overlap up", 8'(11 + i), v[i]);
        chk_reg("R5 overlap up r10 kept", 8'd10, v[0]);
        // R5: overlap, destination below source
        copy_run(8'd10, 8'd11, 9'd4, cyc);
        for (int i = 0; i < 4; i++) chk_reg("R5 overlap down", 8'(10 + i), v[i]);
        // R5: zero register as source and as destination
        wr(8'd30, 64'h77); wr(8'd31, 64'h88);
        copy_run(8'd30, 8'd0, 9'd2, cyc);
        chk_reg("R5 source r0 gives zero", 8'd30, 64'd0);
        chk_reg("R5 source r1 after r0", 8'd31, K1);
        copy_run(8'd0, 8'd20, 9'd2, cyc);
        chk_reg("R5 dest r0 dropped", 8'd0, 64'd0);
        chk_reg("R5 dest r1 written", 8'd1, v[1]);

        // R11: command during copy is ignored
        issue(1, 0, 0, 0, 8'd50, 8'd20, 6'd0, 9'd4, 256'b0);
        issue(0, 0, 0, 1, 8'd40, 8'd0, 6'd0, 9'd0, {192'b0, 64'hBEEF});
        while (busy) @(negedge clk);
        chk_reg("R11 write during busy ignored", 8'd40, 64'd0);
        chk_reg("R11 copy finished", 8'd53, v[3]);

        // R7: copy range limits
        wr(8'd70, 64'h99);
        issue(1, 0, 0, 0, 8'd70, 8'd250, 6'd0, 9'd7, 256'b0);
        chk("R7 source past end exc", {63'b0, exc}, 64'd1);
        chk("R7 source past end no busy", {63'b0, busy}, 64'd0);
        chk_reg("R7 source past end r70 kept", 8'd70, 64'h99);
        issue(1, 0, 0, 0, 8'd253, 8'd10, 6'd0, 9'd4, 256'b0);
        chk("R7 dest past end exc", {63'b0, exc}, 64'd1);
        chk_reg("R7 dest past end r253 kept", 8'd253, 64'h0807060504030201);
        copy_run(8'd252, 8'd10, 9'd4, cyc);
        chk("R7 copy to r255 busy cycles", 64'(cyc), 64'd4);
        chk_reg("R7 copy to r255 value", 8'd255, v[3]);
        // R6: zero count copy
        issue(1, 0, 0, 0, 8'd60, 8'd10, 6'd0, 9'd0, 256'b0);
        chk("R6 zero count no busy", {63'b0, busy}, 64'd0);
        chk("R6 zero count no exc", {63'b0, exc}, 64'd0);

        // R10: priority between simultaneous strobes
        copy_run(8'd80, 8'd10, 9'd1, cyc);
        chk_reg("R10 setup r80", 8'd80, v[0]);
        wr(8'd80, 64'h0);
        issue(1, 0, 0, 1, 8'd80, 8'd10, 6'd0, 9'd1, {192'b0, 64'hBAD});
        while (busy) @(negedge clk);
        chk_reg("R10 copy beats write", 8'd80, v[0]);
        issue(0, 1, 1, 0, 8'd5, 8'd6, 6'd8, 9'd0, wd);
        chk_reg("R10 swap beats wide r5", 8'd5, 64'd0);
        chk_reg("R10 swap beats wide r6", 8'd6, 64'h2222);
        issue(0, 0, 1, 1, 8'd90, 8'd0, 6'd2, 9'd0, wd);
        chk_reg("R10 wide beats write", 8'd90, 64'h0201);

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            summary();
            $finish;
        end
    end

endmodule